// File: doc/BRIEF.md
# Grouped Pin Change Interrupt Controller

This block watches 24 input pins, split into three groups of eight, and raises one interrupt request per group whenever any selected pin in that group toggles in either direction. Every pin first passes through a two-flop synchroniser. A pin change is the difference between the synchronised value and its value one cycle earlier. That difference is filtered by a per-pin mask and then latched into a sticky pending flag for the pin's group.

Each group's request output is its pending flag, gated by a per-group enable bit and by a global interrupt enable input. Software configures the block through a small register bus with an address, a write strobe, write data and combinational read data. A flag is cleared by an acknowledge pulse from the interrupt dispatcher for that group, or by software writing a one to the flag bit.

Top module: `pcint_group_top`

## Requirements
- R1: Group g owns pins 8g to 8g+7 and has one flag (bit g of the flag register) and one request (irqReq[g]). A change on a selected pin sets only the flag of that pin's group.
- R2: A rising or a falling change on a selected pin each set the group flag.
- R3: Each pin has a mask bit in its group's mask register (address g, bit i selects pin 8g+i). A change on a pin whose mask bit is zero has no effect. All mask registers reset to zero.
- R4: The group enable register at address 3 holds the enable for group g in bit g. Bits 7 to 3 always read zero and ignore writes. The register resets to zero.
- R5: irqReq[g] is high exactly when flag g, group enable g and globalIe are all one.
- R6: A flag is set by a selected pin change even while its group enable or globalIe is zero. In that case no request is raised.
- R7: A flag clears on a one-cycle ackVec[g] pulse, or when software writes a one to bit g of the flag register at address 4. Writing zero to a flag bit leaves it unchanged.
- R8: A flag becomes visible after the third rising clock edge following a pin change, and is not yet set after the second.
- R9: After reset, all flags, all requests and all register reads are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 24 | Asynchronous input pins, group g at bits 8g+7:8g |
| globalIe | input | 1 | Global interrupt enable |
| ackVec | input | 3 | Per-group acknowledge pulse from vector dispatch |
| busAddr | input | 3 | Register address: 0-2 masks, 3 enable, 4 flags |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 8 | Register write data |
| busRdData | output | 8 | Combinational register read data |
| irqReq | output | 3 | Per-group interrupt request |

## Verification
The assertions take for granted that the register bus is driven synchronously and stays stable around each rising edge. They also assume that ackVec is only a pulse for a group whose flag is pending. The pin inputs themselves may be fully asynchronous. The stimulus changes pins, bus signals and acknowledges only on the falling clock edge. Before each new pin pattern it keeps the pins stable long enough for the synchroniser to settle, so every change is seen exactly once.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  localparam int PCI_GROUPS  = 3;
  localparam int PCI_GROUP_W = 8;
  localparam int PCI_DATA_W  = 8;
  localparam int PCI_ADDR_W  = 3;

  typedef struct packed {
    logic [PCI_GROUPS-1:0] maskWe;
    logic                  enWe;
    logic [PCI_GROUPS-1:0] flagClr;
    logic [PCI_ADDR_W-1:0] rdSel;
  } pci_strobes_t;
endpackage

// File: rtl/pcint_ctrl.sv
module pcint_ctrl
  import pcint_pkg::*;
#(
  parameter int NG = PCI_GROUPS,
  parameter int DW = PCI_DATA_W,
  parameter int AW = PCI_ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrEn,
  input  logic [DW-1:0] busWrData,
  input  logic [NG-1:0] ackVec,
  output pci_strobes_t  strb
);
  localparam logic [AW-1:0] EN_ADDR   = AW'(NG);
  localparam logic [AW-1:0] FLAG_ADDR = AW'(NG + 1);

  logic [NG-1:0] swClr;

  always_comb begin
    strb = '0;
    strb.rdSel = busAddr;
    for (int g = 0; g < NG; g++) begin
      strb.maskWe[g] = busWrEn && (busAddr == AW'(g));
    end
    strb.enWe = busWrEn && (busAddr == EN_ADDR);
    swClr = (busWrEn && (busAddr == FLAG_ADDR)) ? busWrData[NG-1:0] : '0;
    strb.flagClr = swClr | ackVec;
  end

  // R7: a software clear strobe only exists for bits written as one
  a_r7_w1c_only_ones: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == FLAG_ADDR && ackVec == '0) |-> (strb.flagClr == busWrData[NG-1:0]));
  // R3/R4: at most one register is targeted by a write
  a_r4_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.maskWe, strb.enWe}) <= 1);
endmodule

// File: rtl/pcint_datapath.sv
module pcint_datapath
  import pcint_pkg::*;
#(
  parameter int NG = PCI_GROUPS,
  parameter int GW = PCI_GROUP_W,
  parameter int DW = PCI_DATA_W,
  parameter int AW = PCI_ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NG*GW-1:0] pinIn,
  input  logic          globalIe,
  input  logic [DW-1:0] wrData,
  input  pci_strobes_t  strb,
  output logic [DW-1:0] rdData,
  output logic [NG-1:0] irqReq
);
  localparam int NP = NG * GW;

  logic [NP-1:0] syncA, syncB, prevB, pinChg;
  logic [GW-1:0] maskReg [NG];
  logic [NG-1:0] enReg, flagReg, setEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  assign pinChg = syncB ^ prevB;

  for (genvar g = 0; g < NG; g++) begin : gGrp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) maskReg[g] <= '0;
      else if (strb.maskWe[g]) maskReg[g] <= wrData[GW-1:0];
    end
    assign setEv[g] = |(pinChg[g*GW +: GW] & maskReg[g]);

    // R6: a selected change always lands in the flag, regardless of enables
    a_r6_set_on_change: assert property (@(posedge clk) disable iff (!rstN)
      setEv[g] |=> flagReg[g]);
    // R7: an acknowledge with no new event empties the flag
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
      (strb.flagClr[g] && !setEv[g]) |=> !flagReg[g]);
    // R3: a flag only rises after a masked-in change
    a_r3_rise_needs_event: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagReg[g]) |-> $past(setEv[g]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= '0;
      flagReg <= '0;
    end else begin
      if (strb.enWe) enReg <= wrData[NG-1:0];
      flagReg <= (flagReg & ~strb.flagClr) | setEv;
    end
  end

  assign irqReq = flagReg & enReg & {NG{globalIe}};

  always_comb begin
    rdData = '0;
    for (int g = 0; g < NG; g++) begin
      if (strb.rdSel == AW'(g)) rdData[GW-1:0] = maskReg[g];
    end
    if (strb.rdSel == AW'(NG))     rdData[NG-1:0] = enReg;
    if (strb.rdSel == AW'(NG + 1)) rdData[NG-1:0] = flagReg;
  end

  // R5: no request can leave without the global enable
  a_r5_irq_needs_gie: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq != '0) |-> globalIe);
  // R4: reserved enable bits never read back as one
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == AW'(NG)) |-> (rdData[DW-1:NG] == '0));
endmodule

// File: rtl/pcint_group_top.sv
module pcint_group_top
  import pcint_pkg::*;
#(
  parameter int NG = PCI_GROUPS,
  parameter int GW = PCI_GROUP_W,
  parameter int DW = PCI_DATA_W,
  parameter int AW = PCI_ADDR_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NG*GW-1:0] pinIn,
  input  logic             globalIe,
  input  logic [NG-1:0]    ackVec,
  input  logic [AW-1:0]    busAddr,
  input  logic             busWrEn,
  input  logic [DW-1:0]    busWrData,
  output logic [DW-1:0]    busRdData,
  output logic [NG-1:0]    irqReq
);
  pci_strobes_t strb;

  pcint_ctrl #(.NG(NG), .DW(DW), .AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .ackVec(ackVec), .strb(strb)
  );

  pcint_datapath #(.NG(NG), .GW(GW), .DW(DW), .AW(AW)) uDp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .globalIe(globalIe),
    .wrData(busWrData), .strb(strb), .rdData(busRdData), .irqReq(irqReq)
  );
endmodule

// File: tb/tb_pcint_group_top.sv
module tb_pcint_group_top;
  logic        clk = 0;
  logic        rstN = 0;
  logic [23:0] pinIn = '0;
  logic        globalIe = 0;
  logic [2:0]  ackVec = '0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [2:0]  irqReq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pcint_group_top dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .globalIe(globalIe), .ackVec(ackVec),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .irqReq(irqReq)
  );

  // {pins[29:6], expected flags[5:3], expected irq[2:0]}; masks 0F/F0/FF, enable 101, gie 1
  localparam logic [29:0] VEC [8] = '{
    {24'h000001, 3'b001, 3'b001},
    {24'h000011, 3'b000, 3'b000},
    {24'h001011, 3'b010, 3'b000},
    {24'h801011, 3'b100, 3'b100},
    {24'h800010, 3'b011, 3'b001},
    {24'h000000, 3'b100, 3'b100},
    {24'hFFFFFF, 3'b111, 3'b101},
    {24'hFFFFFF, 3'b000, 3'b000}
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge clk);
    busWrEn = 0; busWrData = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic setPins(logic [23:0] p);
    @(negedge clk);
    pinIn = p;
  endtask

  task automatic waitEdges(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R9 / R3 / R4: reset values
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check(a < 3 ? "R3 mask reset" : (a == 3 ? "R4 enable reset" : "R9 flag reset"), d, 8'h00);
    end
    check("R9 irq reset", {5'b0, irqReq}, 8'h00);

    // R3: with masks at reset value, toggling pins does nothing
    globalIe = 1;
    setPins(24'hFFFFFF);
    waitEdges(5);
    rd(3'd4, d);
    check("R3 masked after reset", d, 8'h00);
    setPins(24'h000000);
    waitEdges(5);

    // R4: reserved bits ignore writes
    wr(3'd3, 8'hFF);
    rd(3'd3, d);
    check("R4 reserved bits", d, 8'h07);
    wr(3'd3, 8'h00);

    // table walk
    wr(3'd0, 8'h0F);
    wr(3'd1, 8'hF0);
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'h05);
    rd(3'd1, d);
    check("R3 mask readback", d, 8'hF0);
    foreach (VEC[i]) begin
      wr(3'd4, 8'h07);
      setPins(VEC[i][29:6]);
      waitEdges(4);
      rd(3'd4, d);
      check("R1 R2 R3 table flags", d, {5'b0, VEC[i][5:3]});
      check("R5 table irq", {5'b0, irqReq}, {5'b0, VEC[i][2:0]});
    end

    // R8: latency, pins currently FFFFFF
    wr(3'd4, 8'h07);
    setPins(24'hFFFFFE);
    waitEdges(2);
    check("R8 not yet after two edges", {5'b0, irqReq}, 8'h00);
    waitEdges(1);
    check("R8 set after three edges", {5'b0, irqReq}, 8'h01);

    // R7: writing zero keeps the flag, writing one clears it
    wr(3'd4, 8'h00);
    rd(3'd4, d);
    check("R7 write zero keeps", d, 8'h01);
    wr(3'd4, 8'h01);
    rd(3'd4, d);
    check("R7 write one clears", d, 8'h00);

    // R6: flag set with globalIe low, no request
    globalIe = 0;
    setPins(24'h7FFFFE);
    waitEdges(4);
    rd(3'd4, d);
    check("R6 flag without gie", d, 8'h04);
    check("R6 no irq without gie", {5'b0, irqReq}, 8'h00);
    globalIe = 1;
    #1 check("R5 irq once gie set", {5'b0, irqReq}, 8'h04);

    // R7: acknowledge pulse clears only its group
    setPins(24'h7FFFFF);
    waitEdges(4);
    rd(3'd4, d);
    check("R1 two groups pending", d, 8'h05);
    @(negedge clk) ackVec = 3'b100;
    @(negedge clk) ackVec = 3'b000;
    rd(3'd4, d);
    check("R7 ack clears group two only", d, 8'h01);

    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule